// File: doc/BRIEF.md
# Wide-to-narrow read width bridge

This block lets a master with a wide data bus read from a slave with a narrow one, for example a memory with an 8-bit data path. The master issues one ordinary read and waits on its waitrequest. While the master waits, the bridge runs a series of narrow reads on the slave side, one per lane of the wide word. It then presents the joined word and releases waitrequest for a single cycle. The master needs no knowledge of the slave's width.

The ratio of master width to slave width is a parameter, so one design covers a 16-bit master (two narrow reads per access) and a 32-bit master (four). Addresses count narrow units. The k-th narrow read goes to the master address plus k, the reads run in ascending order, and the lowest address lands in the lowest lane. The bridge latches the master address when it accepts a read, and it obeys the slave's waitrequest on every narrow read.

Top module: `rd_width_bridge`

## Requirements
- R1: Each master read produces exactly RATIO = MST_DW/SLV_DW accepted slave reads. A slave read is accepted on a cycle with s_read high and s_waitrequest low. No slave read is active in the cycle in which the master read completes.
- R2: The k-th accepted slave read (k = 0 .. RATIO-1) uses address A+k modulo 2^AW, where A is the master address. The reads come in ascending order.
- R3: The returned word is little-endian. The byte accepted at A+k is placed in m_readdata bits [k*SLV_DW +: SLV_DW].
- R4: While a read is pending, m_waitrequest stays high until all narrow reads have been accepted. It then goes low for exactly one cycle, and the assembled word is valid on m_readdata in that cycle.
- R5: While s_waitrequest is high, the bridge holds s_read high and s_address stable, and it captures no data. Each wait cycle on the slave adds one cycle to the master read.
- R6: The bridge uses the master address sampled in the first cycle of a read. Changes to m_address after that cycle have no effect on the addresses issued or the data returned.
- R7: Reset, whether it is applied while idle or in the middle of a read, leaves s_read low. With m_read low, m_waitrequest is low.
- R8: A new master read may start in the cycle right after a completion. With a slave that never waits, each read takes exactly RATIO+2 cycles with m_read high.
- R9: The same design meets R1 to R5 when built with a 16-bit master and an 8-bit slave (RATIO = 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_address | input | AW | Master address, in narrow units |
| m_read | input | 1 | Master read request |
| m_readdata | output | MST_DW | Assembled wide word |
| m_waitrequest | output | 1 | Master stall; low marks completion |
| s_address | output | AW | Slave address of the current narrow read |
| s_read | output | 1 | Slave read request |
| s_readdata | input | SLV_DW | Narrow data from the slave |
| s_waitrequest | input | 1 | Slave stall |

## Verification
Two widths of the bridge are swept across a range of base addresses, including bases near the top of the address space where the narrow addresses wrap. The sweep runs against slave models that never stall, that stall by an amount depending on the address, and that stall on alternate addresses. Every read is checked for data, issue order, count and exact cycle length. A bridge that swapped lanes, stepped the address wrongly, or captured data during a stall would return a wrong word. One that dropped waitrequest too early, or inserted idle cycles between back-to-back reads, would fail the cycle count. Some reads change the master address in the middle of a read, and some are interrupted by reset, to show that the address latch and the reset state behave as required.

// File: rtl/rwb_pkg.sv
package rwb_pkg;
  typedef enum logic [1:0] {
    RWB_IDLE = 2'd0,
    RWB_RUN  = 2'd1,
    RWB_DONE = 2'd2
  } rwb_state_e;
endpackage

// File: rtl/rwb_seq.sv
module rwb_seq #(
  parameter int AW    = 12,
  parameter int RATIO = 4,
  localparam int CW   = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          m_read,
  input  logic [AW-1:0] m_address,
  input  logic          s_waitrequest,
  output logic          s_read,
  output logic [AW-1:0] s_address,
  output logic [CW-1:0] lane_idx,
  output logic          capture,
  output logic          done
);
  import rwb_pkg::*;

  rwb_state_e state;
  logic       last;

  assign last    = (lane_idx == CW'(RATIO - 1));
  assign capture = (state == RWB_RUN) && !s_waitrequest;
  assign done    = (state == RWB_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RWB_IDLE;
      s_read    <= 1'b0;
      s_address <= '0;
      lane_idx  <= '0;
    end else begin
      case (state)
        RWB_IDLE: begin
          if (m_read) begin
            state     <= RWB_RUN;
            s_read    <= 1'b1;
            s_address <= m_address;
            lane_idx  <= '0;
          end
        end
        RWB_RUN: begin
          if (!s_waitrequest) begin
            if (last) begin
              state  <= RWB_DONE;
              s_read <= 1'b0;
            end else begin
              lane_idx  <= lane_idx + 1'b1;
              s_address <= s_address + 1'b1;
            end
          end
        end
        default: state <= RWB_IDLE;
      endcase
    end
  end

  // R2: consecutive narrow reads step the address by one
  p_addr_step_r2: assert property (@(posedge clk) disable iff (rst)
    (capture && !last) |=> (s_address == $past(s_address) + 1'b1));

  // R5: a stalled narrow read keeps its request and address
  p_stall_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (s_read && s_waitrequest) |=> (s_read && $stable(s_address)));

  // R4: completion only follows the capture of a narrow read
  p_done_after_capture_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(s_read && !s_waitrequest));
endmodule

// File: rtl/rwb_pack.sv
module rwb_pack #(
  parameter int SLV_DW = 8,
  parameter int RATIO  = 4,
  localparam int MST_DW = SLV_DW * RATIO,
  localparam int CW     = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [CW-1:0]     lane_idx,
  input  logic [SLV_DW-1:0] s_readdata,
  output logic [MST_DW-1:0] m_readdata
);
  logic [RATIO-1:0] lane_we;

  for (genvar i = 0; i < RATIO; i++) begin : g_lane
    logic [SLV_DW-1:0] q;
    assign lane_we[i] = capture && (lane_idx == CW'(i));
    always_ff @(posedge clk) begin
      if (rst)             q <= '0;
      else if (lane_we[i]) q <= s_readdata;
    end
    assign m_readdata[i*SLV_DW +: SLV_DW] = q;
  end

  // R3: a captured byte goes to at most one lane
  p_one_lane_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lane_we));
endmodule

// File: rtl/rd_width_bridge.sv
module rd_width_bridge #(
  parameter int MST_DW = 32,
  parameter int SLV_DW = 8,
  parameter int AW     = 12,
  localparam int RATIO = MST_DW / SLV_DW,
  localparam int CW    = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     m_address,
  input  logic              m_read,
  output logic [MST_DW-1:0] m_readdata,
  output logic              m_waitrequest,
  output logic [AW-1:0]     s_address,
  output logic              s_read,
  input  logic [SLV_DW-1:0] s_readdata,
  input  logic              s_waitrequest
);
  logic          capture;
  logic          done;
  logic [CW-1:0] lane_idx;

  rwb_seq #(.AW(AW), .RATIO(RATIO)) u_seq (
    .clk(clk), .rst(rst), .m_read(m_read), .m_address(m_address),
    .s_waitrequest(s_waitrequest), .s_read(s_read), .s_address(s_address),
    .lane_idx(lane_idx), .capture(capture), .done(done)
  );

  rwb_pack #(.SLV_DW(SLV_DW), .RATIO(RATIO)) u_pack (
    .clk(clk), .rst(rst), .capture(capture), .lane_idx(lane_idx),
    .s_readdata(s_readdata), .m_readdata(m_readdata)
  );

  assign m_waitrequest = m_read && !done;

  // R4: the completion cycle lasts one cycle
  p_done_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
    (m_read && !m_waitrequest) |=> !(m_read && !m_waitrequest));

  // R1: no slave read remains open at master completion
  p_no_slave_at_done_r1: assert property (@(posedge clk) disable iff (rst)
    (m_read && !m_waitrequest) |-> !s_read);

  // R7: the cycle after reset leaves the slave idle
  p_reset_idle_r7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !s_read);
endmodule

// File: tb/rd_width_bridge_bench.sv
module rwb_slave_model #(
  parameter int AW = 12,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [1:0]    wmode,
  input  logic          s_read,
  input  logic [AW-1:0] s_address,
  output logic [SW-1:0] s_readdata,
  output logic          s_waitrequest,
  output logic [7:0]    acc_n,
  output logic [AW-1:0] acc_first,
  output logic          seq_ok
);
  logic [3:0]    wcnt;
  logic [AW-1:0] acc_last;

  function automatic logic [SW-1:0] byte_at(input int a);
    return SW'(a * 37 + (a >> 3) + 'h5A);
  endfunction

  function automatic int need(input int a, input int m);
    if (m == 1) return (a * 5 + 1) % 4;
    if (m == 2) return (a % 2) * 3;
    return 0;
  endfunction

  assign s_readdata    = byte_at(int'(s_address));
  assign s_waitrequest = s_read && (int'(wcnt) < need(int'(s_address), int'(wmode)));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wcnt     <= '0;
      acc_n    <= '0;
      seq_ok   <= 1'b1;
      acc_first <= '0;
      acc_last <= '0;
    end else if (s_read) begin
      if (s_waitrequest) wcnt <= wcnt + 1'b1;
      else begin
        wcnt  <= '0;
        acc_n <= acc_n + 1'b1;
        if (acc_n == 0) acc_first <= s_address;
        else if (s_address != acc_last + 1'b1) seq_ok <= 1'b0;
        acc_last <= s_address;
      end
    end
  end
endmodule

module rd_width_bridge_bench;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr = 1'b0;
  logic [1:0] wmode = 2'd0;
  always #5 clk = ~clk;

  logic [AW-1:0] ma_a = '0, ma_b = '0;
  logic          mr_a = 1'b0, mr_b = 1'b0;
  logic [31:0]   md_a;
  logic [15:0]   md_b;
  logic          mw_a, mw_b;
  logic [AW-1:0] sa_a, sa_b;
  logic          sr_a, sr_b, sw_a, sw_b;
  logic [7:0]    sd_a, sd_b;
  logic [7:0]    an_a, an_b;
  logic [AW-1:0] af_a, af_b;
  logic          ok_a, ok_b;

  rd_width_bridge #(.MST_DW(32), .SLV_DW(8), .AW(AW)) u_rd_width_bridge (
    .clk(clk), .rst(rst), .m_address(ma_a), .m_read(mr_a), .m_readdata(md_a),
    .m_waitrequest(mw_a), .s_address(sa_a), .s_read(sr_a), .s_readdata(sd_a),
    .s_waitrequest(sw_a));
  rwb_slave_model #(.AW(AW), .SW(8)) u_slv_a (
    .clk(clk), .rst(rst), .clr(clr), .wmode(wmode), .s_read(sr_a), .s_address(sa_a),
    .s_readdata(sd_a), .s_waitrequest(sw_a), .acc_n(an_a), .acc_first(af_a), .seq_ok(ok_a));

  rd_width_bridge #(.MST_DW(16), .SLV_DW(8), .AW(AW)) u_rd_width_bridge_16 (
    .clk(clk), .rst(rst), .m_address(ma_b), .m_read(mr_b), .m_readdata(md_b),
    .m_waitrequest(mw_b), .s_address(sa_b), .s_read(sr_b), .s_readdata(sd_b),
    .s_waitrequest(sw_b));
  rwb_slave_model #(.AW(AW), .SW(8)) u_slv_b (
    .clk(clk), .rst(rst), .clr(clr), .wmode(wmode), .s_read(sr_b), .s_address(sa_b),
    .s_readdata(sd_b), .s_waitrequest(sw_b), .acc_n(an_b), .acc_first(af_b), .seq_ok(ok_b));

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  task automatic chk(input bit cond, input string tag, input longint act, input longint exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_byte(input int a);
    return 8'(a * 37 + (a >> 3) + 'h5A);
  endfunction

  function automatic int ref_need(input int a, input int m);
    if (m == 1) return (a * 5 + 1) % 4;
    if (m == 2) return (a % 2) * 3;
    return 0;
  endfunction

  // one master read; sel=1 uses the 16-bit bridge
  task automatic do_read(input bit sel, input int base, input int mode, input bit scramble);
    int ratio = sel ? 2 : 4;
    int cyc = 1;
    int exp_cyc;
    longint exp_data = 0;
    longint got;
    string w = sel ? "R9 " : "";
    exp_cyc = ratio + 2;
    for (int k = 0; k < ratio; k++) begin
      int a = (base + k) % (1 << AW);
      exp_data |= longint'(ref_byte(a)) << (8 * k);
      exp_cyc += ref_need(a, mode);
    end
    wmode = 2'(mode);
    clr = 1'b1;
    if (sel) begin mr_b = 1'b1; ma_b = AW'(base); end
    else     begin mr_a = 1'b1; ma_a = AW'(base); end
    #1;
    while (sel ? mw_b : mw_a) begin
      @(negedge clk);
      clr = 1'b0;
      if (scramble && cyc == 1) begin
        if (sel) ma_b = ~AW'(base); else ma_a = ~AW'(base);
      end
      cyc++;
      #1;
      if (cyc > 100) break;
    end
    got = sel ? longint'(md_b) : longint'(md_a);
    chk(got == exp_data, {w, scramble ? "R6 data with moved address" : "R3 little-endian data"},
        got, exp_data);
    chk(cyc == exp_cyc, {w, mode == 0 ? "R8 latency" : "R5 latency with stalls"}, cyc, exp_cyc);
    chk((sel ? an_b : an_a) == 8'(ratio), {w, "R1 narrow read count"},
        sel ? an_b : an_a, ratio);
    chk((sel ? af_b : af_a) == AW'(base) && (sel ? ok_b : ok_a),
        {w, "R2 ascending addresses"}, sel ? af_b : af_a, base);
    @(negedge clk);
    clr = 1'b0;
    if (sel) mr_b = 1'b0; else mr_a = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk(!sr_a && !mw_a, "R7 reset idle 32-bit", {sr_a, mw_a}, 0);
    chk(!sr_b && !mw_b, "R7 reset idle 16-bit", {sr_b, mw_b}, 0);
    @(negedge clk);

    for (int sel = 0; sel < 2; sel++) begin
      for (int mode = 0; mode < 3; mode++) begin
        for (int i = 0; i < 70; i++) begin
          int base = (i < 64) ? i * 3 : (1 << AW) - 70 + i;
          do_read(sel[0], base, mode, (i % 7) == 3);
          if (i % 5 == 0) begin
            #1;
            chk(!(sel[0] ? mw_b : mw_a) && !(sel[0] ? sr_b : sr_a), "R7 idle between reads",
                sel[0] ? {sr_b, mw_b} : {sr_a, mw_a}, 0);
            @(negedge clk);
          end
        end
      end
    end

    // reset in the middle of a read
    wmode = 2'd1;
    mr_a = 1'b1;
    ma_a = AW'(5);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    mr_a = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!sr_a && !mw_a, "R7 reset during read", {sr_a, mw_a}, 0);
    @(negedge clk);
    do_read(1'b0, 9, 0, 1'b0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule